// File: doc/BRIEF.md
# Calibration Table Band Interpolator

This block picks an oscillator core and band for a requested divider value. It does not run a full calibration search. It keeps a table of 32 calibration points that together span one octave. Each point records a core select, a band code and the integer divider value at which the point was taken. A request carries an integer divider word and a fractional divider word. The block finds the two points that bracket the request and interpolates the band linearly between them. The answer comes back with a single-cycle done pulse a fixed six cycles after the request is taken.

The stored divider values are multiplied by a scale factor. This lets a table built at one comparison frequency serve at another. Software loads or patches entries one at a time through an override write port. The table must hold ascending divider values, because the bracket search is a binary search over the entry index. While a lookup is in flight the block reports busy, and it drops any new request.

Top module: `band_lut_interp`

## Requirements
- R1: After reset, busy_o, done_o, core_o and band_o are all 0, and every table entry is 0.
- R2: A cycle with wr_en_i high replaces the whole entry at wr_addr_i (core, band and divider value). A request whose value equals that entry's scaled point returns that entry's core and band.
- R3: The scaled point of entry k is ndiv_k * scale_i / 128. A scale_i of 128 means unity. The request value is req_nint_i + req_frac_i / 256, and scale_i is captured when the request is accepted.
- R4: Suppose the largest entry lo whose scaled point is at or below the request and the next entry hi share a core. Then band_o = band_lo + (band_hi - band_lo) * (req - p_lo) / (p_hi - p_lo), rounded to the nearest integer with halves rounded away from zero, and core_o is their shared core.
- R5: A request below entry 0's scaled point returns entry 0. A request at or above entry 31's scaled point returns entry 31.
- R6: When the two bracketing entries differ in core, the result is the core and band of the nearer entry. On a tie the lower entry wins.
- R7: A request is accepted on a rising edge where req_i is high and busy_o is low. From that edge, busy_o is high for six cycles. done_o is high for exactly one cycle, starting six edges after acceptance, and busy_o is low in that cycle.
- R8: A req_i that arrives while busy_o is high is ignored. It causes no extra done pulse and does not change the lookup in flight.
- R9: A table write and an accepted request on the same edge: the lookup uses the newly written entry.
- R10: core_o and band_o change only in the cycle where done_o is high, and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Override strobe for one table entry |
| wr_addr_i | input | 5 | Entry index to overwrite |
| wr_core_i | input | 1 | Core select to store |
| wr_band_i | input | 9 | Band code to store |
| wr_n_i | input | 12 | Integer divider value the point was calibrated at |
| req_i | input | 1 | Lookup request |
| req_nint_i | input | 12 | Requested integer divider |
| req_frac_i | input | 8 | Requested fractional divider, in units of 1/256 |
| scale_i | input | 8 | Scale applied to stored divider values, 128 = 1.0 |
| busy_o | output | 1 | Lookup in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| core_o | output | 1 | Selected core |
| band_o | output | 9 | Selected band code |

## Verification
Two functions can land on one clock edge: an override write to a table entry and the acceptance of a request whose bracket depends on that entry. The bench provokes this by driving wr_en_i and req_i together in one cycle. The request is placed exactly on the rewritten point. The check passes only if the returned band is the newly written value and not the old one. A second collision is also exercised: a request pulsed while a lookup is running. It is judged by counting done pulses and by comparing the result against the first request's expected band.

// File: rtl/lutcal_pkg.sv
package lutcal_pkg;
  localparam int CORE_W = 1;
  localparam int BAND_W = 9;
  localparam int NDIV_W = 12;

  typedef struct packed {
    logic [CORE_W-1:0] core;
    logic [BAND_W-1:0] band;
    logic [NDIV_W-1:0] ndiv;
  } cal_pt_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SRCH, ST_CALC} lk_state_e;
endpackage

// File: rtl/lut_table.sv
module lut_table
  import lutcal_pkg::*;
#(
  parameter int N_PTS = 32,
  parameter int IDX_W = $clog2(N_PTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  cal_pt_t          wr_pt_i,
  input  logic [IDX_W-1:0] a_addr_i,
  output cal_pt_t          a_o,
  input  logic [IDX_W-1:0] b_addr_i,
  output cal_pt_t          b_o,
  input  logic [IDX_W-1:0] c_addr_i,
  output cal_pt_t          c_o
);
  cal_pt_t mem_q [N_PTS];

  for (genvar k = 0; k < N_PTS; k++) begin : g_pt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      mem_q[k] <= '0;
      else if (wr_en_i && wr_addr_i == IDX_W'(k))       mem_q[k] <= wr_pt_i;
    end
  end

  assign a_o = mem_q[a_addr_i];
  assign b_o = mem_q[b_addr_i];
  assign c_o = mem_q[c_addr_i];
endmodule

// File: rtl/band_blend.sv
module band_blend
  import lutcal_pkg::*;
#(
  parameter int P_W = 21
) (
  input  logic [P_W-1:0]    r_i,
  input  logic [P_W-1:0]    p_lo_i,
  input  logic [P_W-1:0]    p_hi_i,
  input  cal_pt_t           lo_i,
  input  cal_pt_t           hi_i,
  input  logic              is_last_i,
  output logic [CORE_W-1:0] core_o,
  output logic [BAND_W-1:0] band_o
);
  localparam int DIV_W = BAND_W + P_W + 2;

  logic              under;
  logic [P_W-1:0]    dr, dh, dp;
  logic              neg;
  logic [BAND_W-1:0] mag, step;
  logic [DIV_W-1:0]  numer, denom;

  always_comb begin
    under = r_i < p_lo_i;
    dr    = r_i - p_lo_i;
    dh    = p_hi_i - r_i;
    dp    = p_hi_i - p_lo_i;
    neg   = hi_i.band < lo_i.band;
    mag   = neg ? (lo_i.band - hi_i.band) : (hi_i.band - lo_i.band);
    // round half away from zero: (2*|d|*dr + dp) / (2*dp)
    numer = ((DIV_W'(mag) * DIV_W'(dr)) << 1) + DIV_W'(dp);
    denom = (dp == '0) ? DIV_W'(1) : (DIV_W'(dp) << 1);
    step  = BAND_W'(numer / denom);

    core_o = lo_i.core;
    band_o = lo_i.band;
    if (under || is_last_i) begin
      core_o = lo_i.core;
      band_o = lo_i.band;
    end else if (lo_i.core != hi_i.core) begin
      if (dr > dh) begin
        core_o = hi_i.core;
        band_o = hi_i.band;
      end
    end else begin
      band_o = neg ? (lo_i.band - step) : (lo_i.band + step);
    end
  end
endmodule

// File: rtl/band_lut_interp.sv
module band_lut_interp
  import lutcal_pkg::*;
#(
  parameter int N_PTS      = 32,
  parameter int FRAC_W     = 8,
  parameter int SCALE_W    = 8,
  parameter int SCALE_FRAC = 7
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [$clog2(N_PTS)-1:0]     wr_addr_i,
  input  logic [CORE_W-1:0]            wr_core_i,
  input  logic [BAND_W-1:0]            wr_band_i,
  input  logic [NDIV_W-1:0]            wr_n_i,
  input  logic                         req_i,
  input  logic [NDIV_W-1:0]            req_nint_i,
  input  logic [FRAC_W-1:0]            req_frac_i,
  input  logic [SCALE_W-1:0]           scale_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic [CORE_W-1:0]            core_o,
  output logic [BAND_W-1:0]            band_o
);
  localparam int IDX_W = $clog2(N_PTS);
  localparam int BIT_W = $clog2(IDX_W + 1);
  localparam int SH    = FRAC_W - SCALE_FRAC;
  localparam int P_W   = NDIV_W + SCALE_W + SH;

  function automatic logic [P_W-1:0] scale_pt(input logic [NDIV_W-1:0] n,
                                              input logic [SCALE_W-1:0] s);
    return (P_W'(n) * P_W'(s)) << SH;
  endfunction

  lk_state_e          st_q;
  logic [IDX_W-1:0]   idx_q, cand, hi_idx;
  logic [BIT_W-1:0]   bit_q;
  logic [P_W-1:0]     r_q;
  logic [SCALE_W-1:0] scale_q;
  logic               done_q;
  logic [CORE_W-1:0]  core_q, core_n;
  logic [BAND_W-1:0]  band_q, band_n;
  cal_pt_t            wr_pt, cand_pt, lo_pt, hi_pt;
  logic [P_W-1:0]     p_cand, p_lo, p_hi;

  assign wr_pt  = {wr_core_i, wr_band_i, wr_n_i};
  assign cand   = idx_q | (IDX_W'(1) << bit_q);
  assign hi_idx = idx_q + IDX_W'(1);

  lut_table #(.N_PTS(N_PTS), .IDX_W(IDX_W)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_pt_i  (wr_pt),
    .a_addr_i (cand),
    .a_o      (cand_pt),
    .b_addr_i (idx_q),
    .b_o      (lo_pt),
    .c_addr_i (hi_idx),
    .c_o      (hi_pt)
  );

  assign p_cand = scale_pt(cand_pt.ndiv, scale_q);
  assign p_lo   = scale_pt(lo_pt.ndiv, scale_q);
  assign p_hi   = scale_pt(hi_pt.ndiv, scale_q);

  band_blend #(.P_W(P_W)) u_blend (
    .r_i      (r_q),
    .p_lo_i   (p_lo),
    .p_hi_i   (p_hi),
    .lo_i     (lo_pt),
    .hi_i     (hi_pt),
    .is_last_i(idx_q == IDX_W'(N_PTS - 1)),
    .core_o   (core_n),
    .band_o   (band_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      bit_q   <= '0;
      r_q     <= '0;
      scale_q <= '0;
      done_q  <= 1'b0;
      core_q  <= '0;
      band_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          r_q     <= P_W'({req_nint_i, req_frac_i});
          scale_q <= scale_i;
          idx_q   <= '0;
          bit_q   <= BIT_W'(IDX_W - 1);
          st_q    <= ST_SRCH;
        end
        ST_SRCH: begin
          if (p_cand <= r_q) idx_q <= cand;
          if (bit_q == '0) st_q <= ST_CALC;
          else             bit_q <= bit_q - BIT_W'(1);
        end
        ST_CALC: begin
          core_q <= core_n;
          band_q <= band_n;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = st_q != ST_IDLE;
  assign done_o = done_q;
  assign core_o = core_q;
  assign band_o = band_q;
endmodule

// File: rtl/band_lut_interp_chk.sv
module band_lut_interp_chk #(
  parameter int LAT = 6
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [0:0] core_o,
  input logic [8:0] band_o
);
  logic [7:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  lat_q <= '0;
    else if (req_i && !busy_o)    lat_q <= 8'd1;
    else if (busy_o && lat_q != 8'hff) lat_q <= lat_q + 8'd1;
  end

  assert_accept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> busy_o);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R8: a request taken while busy would restart and stretch this count
  assert_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> lat_q == 8'(LAT + 1));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(core_o) && $stable(band_o)));
endmodule

bind band_lut_interp band_lut_interp_chk u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .req_i (req_i),
  .busy_o(busy_o),
  .done_o(done_o),
  .core_o(core_o),
  .band_o(band_o)
);

// File: tb/band_lut_interp_tb_top.sv
`timescale 1ns/1ps
module band_lut_interp_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_addr_i = '0;
  logic [0:0]  wr_core_i = '0;
  logic [8:0]  wr_band_i = '0;
  logic [11:0] wr_n_i = '0;
  logic        req_i = 1'b0;
  logic [11:0] req_nint_i = '0;
  logic [7:0]  req_frac_i = '0;
  logic [7:0]  scale_i = 8'd128;
  logic        busy_o, done_o;
  logic [0:0]  core_o;
  logic [8:0]  band_o;

  int n_chk = 0, n_fail = 0;
  int m_core [32], m_band [32], m_n [32];

  always #5 clk_i = ~clk_i;

  band_lut_interp dut_i (.*);

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model(input int nint, input int frac, input int sc,
                                output int ec, output int eb);
    longint r, plo, phi, num, d, q;
    int k;
    r = longint'(nint) * 256 + frac;
    k = 0;
    for (int i = 1; i < 32; i++) if (longint'(m_n[i]) * sc * 2 <= r) k = i;
    plo = longint'(m_n[k]) * sc * 2;
    if (r < plo || k == 31) begin ec = m_core[k]; eb = m_band[k]; return; end
    phi = longint'(m_n[k+1]) * sc * 2;
    if (m_core[k] != m_core[k+1]) begin
      if (r - plo <= phi - r) begin ec = m_core[k]; eb = m_band[k]; end
      else begin ec = m_core[k+1]; eb = m_band[k+1]; end
      return;
    end
    d = m_band[k+1] - m_band[k];
    num = (d < 0 ? -d : d) * (r - plo);
    q = (2 * num + (phi - plo)) / (2 * (phi - plo));
    ec = m_core[k];
    eb = int'(d < 0 ? m_band[k] - q : m_band[k] + q);
  endfunction

  task automatic write_pt(input int a, input int c, input int b, input int n);
    wr_en_i = 1'b1; wr_addr_i = 5'(a); wr_core_i = 1'(c); wr_band_i = 9'(b); wr_n_i = 12'(n);
    m_core[a] = c; m_band[a] = b; m_n[a] = n;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // waits after the accepting edge; checks R7 timing and the result
  task automatic wait_done(input string req, input int ec, input int eb);
    int seen = 0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk_i);
      if (i == 1) begin
        req_i = 1'b0; wr_en_i = 1'b0;
        check("R7", "busy after accept", busy_o, 1);
      end
      if (done_o && seen == 0) begin
        seen = i;
        check("R7", "busy low at done", busy_o, 0);
        check(req, "core", core_o, ec);
        check(req, "band", band_o, eb);
      end
    end
    check("R7", "done latency", seen, 7);
  endtask

  task automatic do_req(input string req, input int nint, input int frac, input int sc);
    int ec, eb;
    model(nint, frac, sc, ec, eb);
    req_i = 1'b1; req_nint_i = 12'(nint); req_frac_i = 8'(frac); scale_i = 8'(sc);
    wait_done(req, ec, eb);
  endtask

  task automatic t_reset();
    check("R1", "busy", busy_o, 0);
    check("R1", "done", done_o, 0);
    check("R1", "core", core_o, 0);
    check("R1", "band", band_o, 0);
  endtask

  task automatic t_load();
    for (int k = 0; k < 32; k++)
      write_pt(k, k < 16 ? 0 : 1, k < 16 ? 40 + 28 * k : 30 + 25 * (k - 16), 80 + (80 * k) / 31);
  endtask

  task automatic t_points();
    do_req("R2", m_n[0], 0, 128);
    do_req("R2", m_n[5], 0, 128);
    do_req("R2", m_n[16], 0, 128);
    do_req("R2", m_n[31], 0, 128);
  endtask

  task automatic t_interp();
    do_req("R4", m_n[5], 128, 128);
    do_req("R4", m_n[7] + 1, 77, 128);
    do_req("R4", m_n[20], 200, 128);
    do_req("R4", m_n[27] + 1, 3, 128);
  endtask

  task automatic t_scale();
    // entry 10 (n=105) at scale 64 lands on 52.5
    do_req("R3", 52, 128, 64);
    check("R3", "band at scaled point", band_o, m_band[10]);
    do_req("R3", 60, 40, 64);
    do_req("R3", 230, 17, 255);
  endtask

  task automatic t_clamp();
    do_req("R5", 10, 0, 128);
    check("R5", "low clamp band", band_o, m_band[0]);
    do_req("R5", 2000, 255, 128);
    check("R5", "high clamp band", band_o, m_band[31]);
    do_req("R5", 160, 0, 128);
    check("R5", "last point core", core_o, 1);
  endtask

  task automatic t_core_edge();
    // entry 15 n=118 core 0, entry 16 n=121 core 1
    do_req("R6", 119, 0, 128);
    check("R6", "near lower core", core_o, 0);
    do_req("R6", 120, 0, 128);
    check("R6", "near upper core", core_o, 1);
    do_req("R6", 119, 128, 128);
    check("R6", "tie to lower core", core_o, 0);
  endtask

  task automatic t_override();
    // entry 0 n=80 band 40, entry 1 n=82: halfway gives x.5
    write_pt(1, 0, 71, 82);
    do_req("R4", 81, 0, 128);
    check("R4", "round up half", band_o, 56);
    write_pt(1, 0, 9, 82);
    do_req("R4", 81, 0, 128);
    check("R4", "round down half", band_o, 24);
    write_pt(1, 0, 68, 82);
  endtask

  task automatic t_busy_ignore();
    int ec, eb, dn = 0, at = 0;
    model(m_n[9], 50, 128, ec, eb);
    req_i = 1'b1; req_nint_i = 12'(m_n[9]); req_frac_i = 8'd50; scale_i = 8'd128;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk_i);
      req_i = 1'b0;
      if (i == 3) begin req_i = 1'b1; req_nint_i = 12'(m_n[25]); req_frac_i = 8'd0; end
      if (done_o) begin dn++; at = i; end
    end
    req_i = 1'b0;
    check("R8", "done pulses", dn, 1);
    check("R8", "done position", at, 7);
    check("R8", "band of first request", band_o, eb);
  endtask

  task automatic t_hold();
    int b0 = band_o, c0 = core_o;
    req_nint_i = 12'd150; scale_i = 8'd200; req_frac_i = 8'd9;
    repeat (5) @(negedge clk_i);
    check("R10", "band held", band_o, b0);
    check("R10", "core held", core_o, c0);
  endtask

  task automatic t_same_cycle();
    wr_en_i = 1'b1; wr_addr_i = 5'd20; wr_core_i = 1'b1; wr_band_i = 9'd300; wr_n_i = 12'(m_n[20]);
    m_band[20] = 300;
    req_i = 1'b1; req_nint_i = 12'(m_n[20]); req_frac_i = 8'd0; scale_i = 8'd128;
    wait_done("R9", 1, 300);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_load();
    t_points();
    t_interp();
    t_scale();
    t_clamp();
    t_core_edge();
    t_override();
    t_busy_ignore();
    t_hold();
    t_same_cycle();
    repeat (2) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule